// File: doc/BRIEF.md
# Residue Multiply-Accumulate Channel

This block is a single channel of a residue-number-system multiply-accumulate engine in which every product uses the same fixed coefficient. On each cycle where the input is marked valid, a small residue arriving on the input is turned into its product with the coefficient, reduced modulo the channel modulus. It does this with one constant lookup table: five address bits in, five data bits out. The reduced product is then folded into a running residue held in an accumulator register.

The modulus and the coefficient are elaboration-time parameters, so one design serves every channel of a multi-channel engine. Typical moduli are 32, 31, 29, 27 and 25. A synchronous clear starts a new sum. The accumulated residue is always visible on the output. Binary-to-residue conversion, residue-to-binary conversion and the sibling channels live outside this block.

Top module: `resMacChannel`

## Requirements
- R1: For an input residue x below the modulus m, one accumulation starting from zero leaves the output at (x * COEFF) mod m.
- R2: The accumulated residue on the output is always strictly below m.
- R3: On every rising edge where inValid is high and clear is low, the output becomes (previous output + x * COEFF) mod m. The new value is visible after that edge.
- R4: A clear high at a rising edge forces the output to zero after that edge. This holds even when inValid is high in the same cycle.
- R5: On a rising edge where inValid and clear are both low, the output keeps its value, whatever inRes carries.
- R6: While rstN is low the output is zero, and it stays zero after reset is released until the first accumulation.
- R7: Back-to-back valid cycles each add one product, with no stall cycle between them.
- R8: When the running value plus the product equals m exactly, the result is 0. When the sum exceeds m, the result is the sum minus m.
- R9: An input residue at or above m adds zero. For example, with m = 31, an input of 31 leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of the accumulator; takes priority over inValid |
| inValid | input | 1 | High when inRes carries a residue to accumulate |
| inRes | input | RES_W | Input residue, expected below MODULUS |
| accRes | output | RES_W | Accumulated residue |

## Verification
Some properties are checked on every cycle by the assertions:
- the accumulator never reaches m;
- the corrected adder output stays in range;
- the control never issues clear and load together;
- a load step matches the modular sum of the previous value and the product;
- a cycle without any strobe leaves the register untouched.

Other behaviour can only be shown by the bench scenarios. These are:
- the table contents for concrete coefficients;
- clear winning over valid;
- the exact-m wrap to zero;
- out-of-range inputs adding nothing;
- long random runs that wrap past m many times against an integer model.

// File: rtl/resMacPkg.sv
package resMacPkg;
  // Strobes issued by the control module to the datapath each cycle.
  typedef struct packed {
    logic load;   // add the current product into the accumulator
    logic clear;  // zero the accumulator
  } ctrlStrobes_t;
endpackage

// File: rtl/resModAdder.sv
module resModAdder #(
  parameter int RES_W   = 5,
  parameter int MODULUS = 31
) (
  input  logic [RES_W-1:0] addA,
  input  logic [RES_W-1:0] addB,
  output logic [RES_W-1:0] sumOut
);
  localparam int SUM_W = RES_W + 1;

  logic [SUM_W-1:0] rawSum;
  logic [SUM_W-1:0] corrected;
  logic             overM;

  // Binary add with one carry bit, then a single subtract-and-select correction.
  assign rawSum    = {1'b0, addA} + {1'b0, addB};
  assign corrected = rawSum - SUM_W'(MODULUS);
  assign overM     = (rawSum >= SUM_W'(MODULUS));
  assign sumOut    = overM ? corrected[RES_W-1:0] : rawSum[RES_W-1:0];

  // R8: with operands in range, the corrected sum stays below the modulus.
  always_comb begin
    if ((int'(addA) < MODULUS) && (int'(addB) < MODULUS)) begin
      p_sum_range_r8: assert (int'(sumOut) < MODULUS);
    end
  end
endmodule

// File: rtl/resMacCtrl.sv
module resMacCtrl
  import resMacPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         inValid,
  output ctrlStrobes_t strb
);
  // Clear dominates: an input that arrives together with a clear is dropped.
  always_comb begin
    strb.clear = clear;
    strb.load  = inValid & ~clear;
  end

  // R4: clear and load never issued in the same cycle.
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.clear}));
endmodule

// File: rtl/resMacDatapath.sv
module resMacDatapath
  import resMacPkg::*;
#(
  parameter int RES_W   = 5,
  parameter int MODULUS = 31,
  parameter int COEFF   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [RES_W-1:0] inRes,
  output logic [RES_W-1:0] accOut
);
  localparam int TABLE_N = 2 ** RES_W;

  logic [RES_W-1:0] prodTable [TABLE_N];
  logic [RES_W-1:0] product;
  logic [RES_W-1:0] nextAcc;
  logic [RES_W-1:0] accReg;

  // Constant-coefficient product table built at elaboration.
  // Addresses at or above the modulus hold zero.
  for (genvar i = 0; i < TABLE_N; i++) begin : g_tab
    localparam int ENTRY = (i < MODULUS) ? ((i * COEFF) % MODULUS) : 0;
    assign prodTable[i] = RES_W'(ENTRY);
  end

  assign product = prodTable[inRes];

  // Single-cycle modular feedback adder (not pipelined).
  resModAdder #(.RES_W(RES_W), .MODULUS(MODULUS)) u_add (
    .addA  (accReg),
    .addB  (product),
    .sumOut(nextAcc)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           accReg <= '0;
    else if (strb.clear) accReg <= '0;
    else if (strb.load)  accReg <= nextAcc;
  end

  assign accOut = accReg;

  // R2: running residue always below the modulus.
  p_acc_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    int'(accReg) < MODULUS);

  // R4: a clear strobe yields zero after the edge.
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (accReg == '0));

  // R5: no strobe, no change.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.clear) |=> $stable(accReg));

  // R3: a load step adds the table product modulo m.
  p_load_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (int'(accReg) ==
      ((int'($past(accReg)) + int'($past(product))) % MODULUS)));
endmodule

// File: rtl/resMacChannel.sv
module resMacChannel
  import resMacPkg::*;
#(
  parameter int RES_W   = 5,
  parameter int MODULUS = 31,
  parameter int COEFF   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             inValid,
  input  logic [RES_W-1:0] inRes,
  output logic [RES_W-1:0] accRes
);
  ctrlStrobes_t strb;

  resMacCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (clear),
    .inValid(inValid),
    .strb   (strb)
  );

  resMacDatapath #(.RES_W(RES_W), .MODULUS(MODULUS), .COEFF(COEFF)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .inRes (inRes),
    .accOut(accRes)
  );
endmodule

// File: tb/resMacChannel_test.sv
module resMacChannel_test;
  localparam int RES_W = 5;
  localparam int M     = 31;
  localparam int C     = 7;

  typedef struct {
    int    expVal;
    int    due;
    string tag;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             clear = 1'b0;
  logic             inValid = 1'b0;
  logic [RES_W-1:0] inRes = '0;
  logic [RES_W-1:0] accRes;

  int       checks = 0;
  int       fails = 0;
  int       cycleCount = 0;
  int       modelAcc = 0;
  bit       done = 1'b0;
  expItem_t scoreQ[$];

  resMacChannel #(.RES_W(RES_W), .MODULUS(M), .COEFF(C)) uut (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (clear),
    .inValid(inValid),
    .inRes  (inRes),
    .accRes (accRes)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cycleCount <= cycleCount + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: accRes=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops every expected item whose capture edge has passed.
  always @(negedge clk) begin
    while (scoreQ.size() > 0 && scoreQ[0].due <= cycleCount) begin
      expItem_t it;
      it = scoreQ.pop_front();
      check(it.tag, int'(accRes), it.expVal);
    end
  end

  // Driver: applies one cycle of stimulus, updates the model, queues the expectation.
  task automatic step(input bit v, input int x, input bit clr, input string tag);
    expItem_t it;
    @(posedge clk);
    #2;
    inValid = v;
    inRes   = RES_W'(x);
    clear   = clr;
    if (clr)      modelAcc = 0;
    else if (v)   modelAcc = (x < M) ? (modelAcc + x * C) % M : modelAcc;
    it.expVal = modelAcc;
    it.due    = cycleCount + 1;
    it.tag    = tag;
    scoreQ.push_back(it);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: accRes=%0d expected=done", int'(accRes));
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 in reset", int'(accRes), 0);
    @(posedge clk); #2; rstN = 1'b1;
    @(negedge clk);
    check("R6 after release", int'(accRes), 0);

    // R1: single products from zero
    step(1, 1, 0, "R1 x=1");
    step(0, 0, 1, "R4 clr");
    step(1, 30, 0, "R1 x=30");
    step(0, 0, 1, "R4 clr");
    step(1, 9, 0, "R1 x=9");
    // R4: clear beats valid
    step(1, 5, 1, "R4 clear with valid");
    // R8: 7 + 24 == 31 wraps to 0, then over-m case
    step(1, 1, 0, "R8 setup");
    step(1, 30, 0, "R8 exact m");
    step(1, 30, 0, "R8 after zero");
    step(1, 30, 0, "R8 above m");
    // R5: valid low ignores input
    step(0, 17, 0, "R5 hold");
    step(0, 3, 0, "R5 hold");
    // R9: out-of-range input adds zero
    step(1, 31, 0, "R9 x=31");
    // R7: back-to-back wraps
    for (int i = 0; i < 12; i++) step(1, 29, 0, "R7 back-to-back");
    // R3 / R2: random sequence
    for (int i = 0; i < 400; i++) begin
      int  x;
      bit  v;
      bit  c;
      x = int'($urandom_range(0, M - 1));
      v = ($urandom_range(0, 3) != 0);
      c = ($urandom_range(0, 40) == 0);
      step(v, x, c, "R3 random");
    end
    step(0, 0, 0, "R2 final");
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule